// File: doc/BRIEF.md
# RLL(2,7) Serial Channel Encoder

This block turns a serial stream of user bits into a run-length-limited channel stream. In that stream every pair of neighbouring ones is separated by no fewer than two and no more than seven zeros. The input is split into short words of two, three or four bits. Each word is replaced by a code word of twice its length, so the code rate is fixed at one half. For the same drive electronics, this gives roughly half again the capacity of a modified-frequency-modulation layout.

User bits enter one per beat through a valid/ready pair and collect in a four-bit parse buffer. The word set is prefix-free, so a greedy match from the oldest buffered bit is always unique. Each matched code word is loaded into a shift register and sent one bit per clock on `outBit`, qualified by `outValid`. A flush pulse ends a stream. Whole words still in the buffer go out first. An incomplete tail is then completed with the fewest zero bits that form a valid word, and `padCount` reports how many zeros were added.

Top module: `rll27_enc`

## Requirements
- R1: While reset is held and right after it, `outValid` is low, `padCount` is 0 and `inReady` is high.
- R2: Input bits are parsed oldest first and each code word leaves `outBit` leftmost bit first. Word 10 gives 0100 and word 11 gives 1000.
- R3: Word 000 gives 000100, word 010 gives 100100, and word 011 gives 001000.
- R4: Word 0010 gives 00100100 and word 0011 gives 00001000. The parse is greedy from the oldest bit, with no overlap between words.
- R5: A word loads on the first rising edge at which it sits complete in the buffer and at most one code bit is still to be sent. Its first bit shows with `outValid` high in the cycle after that edge, and its other bits follow one per cycle with no gap. From idle, a word whose last bit is taken at edge k starts after edge k+1.
- R6: `inReady` is low whenever four bits are buffered or a flush is pending. A bit offered while `inReady` is low is not taken.
- R7: The number of code bits sent equals twice the sum of accepted input bits and pad zeros.
- R8: After a flush pulse and any whole words, a partial tail is completed with zeros: 1 becomes 10, 0 becomes 000, 01 becomes 010, 00 becomes 000, and 001 becomes 0010. `padCount` holds the number of zeros added (1 or 2) for every bit of that word, and 0 for words without padding. A flush with nothing left over adds no bits.
- R9: Between any two consecutive ones on the output there are from 2 to 7 zeros, across word boundaries and across flushes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An input bit is offered |
| inBit | input | 1 | The offered input bit |
| flush | input | 1 | One-cycle pulse ending the current stream |
| inReady | output | 1 | The offered bit is taken at this edge |
| outValid | output | 1 | `outBit` carries a code bit this cycle |
| outBit | output | 1 | Serial channel bit |
| padCount | output | 2 | Zeros added to the word now being sent |

## Verification
Every output comes from a register. A word taken from idle shows its first code bit two edges after its last input bit is accepted, and a flushed tail is padded one edge after the flush edge. `inReady` falls in the cycle after the fourth bit enters or the flush is seen. The bench drives inputs on falling edges. Its queue-based model advances on each rising edge from those inputs alone. It compares all four outputs on the next falling edge, one full register stage after the cause. The directed latency and stall checks count falling edges from the acceptance edge by the same rule.

// File: rtl/rll27_pkg.sv
package rll27_pkg;

  // Longest input word of the code; the word table below is built for it.
  localparam int IN_MAX   = 4;
  // Most zeros a flush may append to complete a tail.
  localparam int MAX_PAD  = 2;
  localparam int CODE_MAX = 2 * IN_MAX;
  localparam int CNT_W    = $clog2(IN_MAX + MAX_PAD + 1);
  localparam int SH_W     = $clog2(CODE_MAX + 1);
  localparam int IDX_W    = $clog2(IN_MAX);
  localparam int PAD_W    = $clog2(MAX_PAD + 1);

  typedef logic [IN_MAX-1:0]   buf_t;
  typedef logic [CNT_W-1:0]    cnt_t;
  typedef logic [CODE_MAX-1:0] code_t;
  typedef logic [SH_W-1:0]     rem_t;

  // Which probe result the datapath loads into the shifter.
  typedef enum logic [1:0] {SEL_NONE, SEL_DIRECT, SEL_PAD1, SEL_PAD2} sel_e;

  typedef struct packed {
    logic  hit;
    cnt_t  len;    // input word length
    code_t code;   // code word, left aligned, first bit at MSB
  } match_t;

  typedef struct packed {
    cnt_t                 bufCnt;
    rem_t                 shRem;
    match_t [MAX_PAD:0]   probe;   // probe[p]: match with p zeros appended
  } dpStat_t;

  typedef struct packed {
    sel_e  sel;
    cnt_t  take;
    logic  accept;
  } strobe_t;

  // Greedy lookup on the first n bits of b (b[IN_MAX-1] oldest, unused bits zero).
  function automatic match_t findWord(buf_t b, cnt_t n);
    match_t m;
    m = '0;
    if (n >= cnt_t'(2) && b[3]) begin
      m.hit  = 1'b1;
      m.len  = cnt_t'(2);
      m.code = b[2] ? 8'b1000_0000 : 8'b0100_0000;
    end else if (n >= cnt_t'(3) && !b[3]) begin
      if (b[2:1] == 2'b00) begin
        m.hit = 1'b1; m.len = cnt_t'(3); m.code = 8'b0001_0000;
      end else if (b[2:1] == 2'b10) begin
        m.hit = 1'b1; m.len = cnt_t'(3); m.code = 8'b1001_0000;
      end else if (b[2:1] == 2'b11) begin
        m.hit = 1'b1; m.len = cnt_t'(3); m.code = 8'b0010_0000;
      end else if (n >= cnt_t'(4)) begin
        m.hit  = 1'b1;
        m.len  = cnt_t'(4);
        m.code = b[0] ? 8'b0000_1000 : 8'b0010_0100;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/rll27_dp.sv
module rll27_dp
  import rll27_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               inBit,
  output dpStat_t            stat,
  output logic               outValid,
  output logic               outBit,
  output logic [PAD_W-1:0]   padCount
);

  localparam int PROBES = MAX_PAD + 1;

  buf_t             bufReg, bufNext;
  cnt_t             bufCnt, cntNext;
  code_t            shReg;
  rem_t             shRem;
  logic [PAD_W-1:0] padReg, padAmt;
  logic [IDX_W-1:0] slot;
  match_t           probe [PROBES];
  match_t           chosen;

  // One matcher per possible number of appended zeros.
  for (genvar p = 0; p < PROBES; p++) begin : g_probe
    assign probe[p] = findWord(bufReg, bufCnt + cnt_t'(p));
  end

  always_comb begin
    stat.bufCnt = bufCnt;
    stat.shRem  = shRem;
    for (int p = 0; p < PROBES; p++) stat.probe[p] = probe[p];
  end

  always_comb begin
    chosen = '0;
    padAmt = '0;
    unique case (stb.sel)
      SEL_DIRECT: chosen = probe[0];
      SEL_PAD1: begin chosen = probe[1]; padAmt = PAD_W'(1); end
      SEL_PAD2: begin chosen = probe[2]; padAmt = PAD_W'(2); end
      default:  chosen = '0;
    endcase
  end

  // Drop consumed bits from the old end, then append the new bit.
  always_comb begin
    bufNext = bufReg;
    cntNext = bufCnt;
    slot    = '0;
    if (stb.sel != SEL_NONE) begin
      bufNext = bufReg << stb.take;
      cntNext = bufCnt - stb.take;
    end
    if (stb.accept) begin
      slot          = IDX_W'(IN_MAX - 1) - IDX_W'(cntNext);
      bufNext[slot] = inBit;
      cntNext       = cntNext + cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg <= '0;
      bufCnt <= '0;
    end else begin
      bufReg <= bufNext;
      bufCnt <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      shRem  <= '0;
      padReg <= '0;
    end else if (stb.sel != SEL_NONE) begin
      shReg  <= chosen.code;
      shRem  <= rem_t'({chosen.len, 1'b0});
      padReg <= padAmt;
    end else if (shRem != '0) begin
      shReg  <= shReg << 1;
      shRem  <= shRem - rem_t'(1);
    end
  end

  assign outValid = (shRem != '0);
  assign outBit   = shReg[CODE_MAX-1];
  assign padCount = padReg;

endmodule

// File: rtl/rll27_ctrl.sv
module rll27_ctrl
  import rll27_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    inValid,
  input  logic    flush,
  output strobe_t stb,
  output logic    inReady
);

  logic flushPend;
  logic shFree;
  logic found;

  assign shFree  = (stat.shRem <= rem_t'(1));
  assign inReady = !flushPend && (stat.bufCnt < cnt_t'(IN_MAX));

  always_comb begin
    stb   = '0;
    found = 1'b0;
    if (shFree) begin
      if (stat.probe[0].hit) begin
        stb.sel  = SEL_DIRECT;
        stb.take = stat.probe[0].len;
      end else if (flushPend && stat.bufCnt != '0) begin
        // Fewest appended zeros wins.
        for (int p = 1; p <= MAX_PAD; p++) begin
          if (!found && stat.probe[p].hit) begin
            found    = 1'b1;
            stb.sel  = sel_e'(2'(p + 1));
            stb.take = stat.bufCnt;
          end
        end
      end
    end
    stb.accept = inValid && inReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flushPend <= 1'b0;
    else       flushPend <= flush || (flushPend && (stat.bufCnt != stb.take));
  end

endmodule

// File: rtl/rll27_enc.sv
module rll27_enc
  import rll27_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inBit,
  input  logic             flush,
  output logic             inReady,
  output logic             outValid,
  output logic             outBit,
  output logic [PAD_W-1:0] padCount
);

  strobe_t stb;
  dpStat_t dpStat;

  rll27_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (dpStat),
    .inValid (inValid),
    .flush   (flush),
    .stb     (stb),
    .inReady (inReady)
  );

  rll27_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inBit    (inBit),
    .stat     (dpStat),
    .outValid (outValid),
    .outBit   (outBit),
    .padCount (padCount)
  );

endmodule

// File: rtl/rll27_chk.sv
module rll27_chk
  import rll27_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             flush,
  input logic             outValid,
  input logic             outBit,
  input logic [PAD_W-1:0] padCount,
  input dpStat_t          stat
);

  logic [3:0] zeroRun;
  logic       seenOne;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
      seenOne <= 1'b0;
    end else if (outValid) begin
      if (outBit) begin
        zeroRun <= '0;
        seenOne <= 1'b1;
      end else if (zeroRun != 4'hF) begin
        zeroRun <= zeroRun + 4'd1;
      end
    end
  end

  // R6
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.bufCnt <= cnt_t'(IN_MAX));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady && !flush) |=> (stat.bufCnt <= $past(stat.bufCnt)));

  // R5
  word_gapless_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stat.shRem > rem_t'(1)) |=> (outValid && stat.shRem == $past(stat.shRem) - rem_t'(1)));

  // R7
  word_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid) |=> (stat.shRem inside {rem_t'(0), rem_t'(4), rem_t'(6), rem_t'(8)}));

  // R8
  pad_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stat.shRem > rem_t'(1)) |=> $stable(padCount));

  // R8
  pad_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (padCount <= PAD_W'(MAX_PAD)));

  // R9
  run_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outBit && seenOne) |-> (zeroRun >= 4'd2));

  // R9
  run_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outBit && seenOne) |-> (zeroRun < 4'd7));

endmodule

bind rll27_enc rll27_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .flush    (flush),
  .outValid (outValid),
  .outBit   (outBit),
  .padCount (padCount),
  .stat     (dpStat)
);

// File: tb/rll27_enc_test.sv
`timescale 1ns/1ps
module rll27_enc_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inBit = 1'b0;
  logic       flush = 1'b0;
  logic       inReady, outValid, outBit;
  logic [1:0] padCount;

  always #2 clk = ~clk;

  rll27_enc uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit), .flush(flush),
    .inReady(inReady), .outValid(outValid), .outBit(outBit), .padCount(padCount)
  );

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;
  bit comparing = 1'b0;

  // Behavioural model state
  bit mBuf[$];
  bit mSh[$];
  int mPad = 0;
  bit mFlushPend = 1'b0;
  bit mAcc = 1'b0;
  int accCnt = 0;
  int padSum = 0;

  // Output log
  bit oLog[$];
  int pLog[$];

  string wIn [7] = '{"10", "11", "000", "010", "011", "0010", "0011"};
  string wOut[7] = '{"0100", "1000", "000100", "100100", "001000", "00100100", "00001000"};

  task automatic report(bit ok, string msg);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int lookWord(bit q[$], int n);
    int hitIdx = -1;
    for (int k = 0; k < 7; k++) begin
      bit same = 1'b1;
      if (wIn[k].len() > n) same = 1'b0;
      for (int j = 0; j < wIn[k].len(); j++) begin
        bit b = (j < q.size()) ? q[j] : 1'b0;
        if (b != (wIn[k][j] == "1")) same = 1'b0;
      end
      if (same) hitIdx = k;
    end
    return hitIdx;
  endfunction

  task automatic pushCode(int k);
    for (int j = 0; j < wOut[k].len(); j++) mSh.push_back(wOut[k][j] == "1");
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBuf.delete(); mSh.delete();
      mPad = 0; mFlushPend = 1'b0; mAcc = 1'b0;
    end else begin
      bit free, rdy, got;
      int k;
      free = (mSh.size() <= 1);
      rdy  = !mFlushPend && (mBuf.size() < 4);
      mAcc = inValid && rdy;
      if (mSh.size() != 0) void'(mSh.pop_front());
      if (free) begin
        k = lookWord(mBuf, mBuf.size());
        if (k >= 0) begin
          pushCode(k);
          for (int j = 0; j < wIn[k].len(); j++) void'(mBuf.pop_front());
          mPad = 0;
        end else if (mFlushPend && mBuf.size() != 0) begin
          got = 1'b0;
          for (int p = 1; p <= 2; p++) begin
            if (!got) begin
              k = lookWord(mBuf, mBuf.size() + p);
              if (k >= 0) begin
                got = 1'b1;
                pushCode(k);
                mPad = p;
                padSum += p;
                mBuf.delete();
              end
            end
          end
        end
      end
      if (mAcc) begin
        mBuf.push_back(inBit);
        accCnt++;
      end
      mFlushPend = flush || (mFlushPend && mBuf.size() != 0);
    end
  end

  // Per-cycle comparison and output logging, away from the active edge
  always @(negedge clk) begin
    if (comparing && rstN && !done) begin
      bit eValid, eReady, ok;
      eValid = (mSh.size() != 0);
      eReady = !mFlushPend && (mBuf.size() < 4);
      ok = 1'b1;
      if (inReady !== eReady) begin
        ok = 1'b0;
        $display("FAIL R6 inReady act=%0b exp=%0b t=%0t", inReady, eReady, $time);
      end
      if (outValid !== eValid) begin
        ok = 1'b0;
        $display("FAIL R5 outValid act=%0b exp=%0b t=%0t", outValid, eValid, $time);
      end
      if (eValid && outBit !== mSh[0]) begin
        ok = 1'b0;
        $display("FAIL R2/R3/R4 outBit act=%0b exp=%0b t=%0t", outBit, mSh[0], $time);
      end
      if (eValid && int'(padCount) != mPad) begin
        ok = 1'b0;
        $display("FAIL R8 padCount act=%0d exp=%0d t=%0t", padCount, mPad, $time);
      end
      nCmp++;
      if (!ok) nBad++;
    end
    if (rstN && outValid) begin
      oLog.push_back(outBit);
      pLog.push_back(int'(padCount));
    end
  end

  task automatic sendBit(bit b);
    int w = 0;
    inValid = 1'b1;
    inBit   = b;
    do begin
      @(negedge clk);
      w++;
    end while (!mAcc && w < 100);
    inValid = 1'b0;
  endtask

  task automatic sendStr(string s);
    for (int i = 0; i < s.len(); i++) sendBit(s[i] == "1");
  endtask

  task automatic pulseFlush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic drain();
    int w = 0;
    do begin
      @(negedge clk);
      w++;
    end while ((mSh.size() != 0 || mBuf.size() != 0 || mFlushPend) && w < 200);
    @(negedge clk);
  endtask

  function automatic string logStr();
    string s = "";
    foreach (oLog[i]) s = {s, oLog[i] ? "1" : "0"};
    return s;
  endfunction

  task automatic expectLog(string exp, string tag);
    string got = logStr();
    report(got == exp, $sformatf("%s code stream act=%s exp=%s", tag, got, exp));
  endtask

  task automatic expectLastPad(int exp, string tag);
    int act = (pLog.size() != 0) ? pLog[pLog.size()-1] : -1;
    report(act == exp, $sformatf("%s padCount act=%0d exp=%0d", tag, act, exp));
  endtask

  task automatic flushCase(string tail, string exp, int pad, string tag);
    oLog.delete(); pLog.delete();
    sendStr(tail);
    pulseFlush();
    drain();
    expectLog(exp, tag);
    expectLastPad(pad, tag);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    report(outValid == 1'b0 && inReady == 1'b1 && padCount == 2'd0,
      $sformatf("R1 reset outputs act=%0b%0b%0d exp=010", outValid, inReady, padCount));
    rstN = 1'b1;
    @(negedge clk);
    // R1: after reset release
    report(outValid == 1'b0 && inReady == 1'b1 && padCount == 2'd0,
      $sformatf("R1 post-reset outputs act=%0b%0b%0d exp=010", outValid, inReady, padCount));
    comparing = 1'b1;

    // R2
    oLog.delete(); pLog.delete();
    sendStr("1011"); drain();
    expectLog("01001000", "R2");
    expectLastPad(0, "R2");

    // R3
    oLog.delete();
    sendStr("000010011"); drain();
    expectLog("000100100100001000", "R3");

    // R4: greedy four-bit words
    oLog.delete();
    sendStr("00100011"); drain();
    expectLog("0010010000001000", "R4");

    // R2 R3 mixed stream
    oLog.delete();
    sendStr("101001011"); drain();
    expectLog("010001001001001000", "R3");

    // R5: latency and gapless bits from idle
    begin
      int run = 0;
      sendBit(1'b1);
      sendBit(1'b0);
      report(outValid == 1'b0, $sformatf("R5 one edge after last bit act=%0b exp=0", outValid));
      @(negedge clk);
      report(outValid == 1'b1, $sformatf("R5 two edges after last bit act=%0b exp=1", outValid));
      while (outValid && run < 20) begin
        run++;
        @(negedge clk);
      end
      report(run == 4, $sformatf("R5 word duration act=%0d exp=4", run));
    end
    drain();

    // R8: padding of every partial tail
    flushCase("1",   "0100",     1, "R8");
    flushCase("0",   "000100",   2, "R8");
    flushCase("01",  "100100",   1, "R8");
    flushCase("00",  "000100",   1, "R8");
    flushCase("001", "00100100", 1, "R8");
    flushCase("11",  "1000",     0, "R8");

    // R6: flush pending blocks input; the offered bit is ignored
    oLog.delete(); pLog.delete();
    sendBit(1'b0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    report(inReady == 1'b0, $sformatf("R6 inReady while flush pending act=%0b exp=0", inReady));
    inValid = 1'b1;
    inBit   = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    drain();
    pulseFlush();
    drain();
    expectLog("000100", "R6");

    // R6: continuous offering fills the buffer and stalls
    begin
      int lowSeen = 0;
      oLog.delete();
      inValid = 1'b1;
      for (int c = 0; c < 40; c++) begin
        inBit = 1'($urandom);
        @(negedge clk);
        if (!inReady) lowSeen++;
      end
      inValid = 1'b0;
      pulseFlush();
      drain();
      report(lowSeen > 0, $sformatf("R6 stall cycles act=%0d exp>0", lowSeen));
    end

    // Random streams with flushes: R7 and R9 over the concatenation
    oLog.delete(); pLog.delete();
    accCnt = 0;
    padSum = 0;
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 300; c++) begin
        inValid = (($urandom % 8) != 0);
        inBit   = 1'($urandom);
        @(negedge clk);
      end
      inValid = 1'b0;
      pulseFlush();
      drain();
    end
    report(oLog.size() == 2 * (accCnt + padSum),
      $sformatf("R7 code bit count act=%0d exp=%0d", oLog.size(), 2 * (accCnt + padSum)));
    begin
      int run = 0;
      bit seen = 1'b0;
      int badRuns = 0;
      foreach (oLog[i]) begin
        if (oLog[i]) begin
          if (seen && (run < 2 || run > 7)) badRuns++;
          seen = 1'b1;
          run = 0;
        end else begin
          run++;
        end
      end
      report(badRuns == 0, $sformatf("R9 zero runs out of range act=%0d exp=0", badRuns));
    end

    finishRun();
  end

endmodule